// File: doc/BRIEF.md
# ALU Built-In Self-Test Sequencer

This block runs a fixed, deterministic test program against a 32-bit arithmetic/logic datapath that sits beside it. After a start strobe it issues one operation at a time on an opcode/operand bus. The program covers four groups of operations:

- a rotate chain seeded with the value one;
- logic operations on all-zero and all-one operand words;
- add/subtract operations, including carry-stressing corner cases;
- a complete 4-bit by 4-bit multiplication sweep.

The datapath returns each result a fixed number of cycles after the operation is issued. The sequencer folds every returned result into a multiple-input signature register. Results are never stored one by one.

When the last result has been folded in, the block raises a done flag and holds it. It also raises a pass flag when the final signature equals a golden constant, which the integrator supplies as a parameter. The rotate chain is truly sequential: each rotate uses the previous returned result as its operand. This makes the feedback path of the datapath part of the test. The other groups issue back to back, one operation per cycle.

Top module: `alu_bist_seq`

## Requirements
- R1: After synchronous reset, and whenever no test is running, op_valid is 0. After reset, done, pass and signature are all 0.
- R2: A start pulse accepted while idle or done clears the signature to 0. In the next cycle the block issues its first operation: code 0 (rotate right by one), op_a = 1, op_b = 0.
- R3: The rotate group has 2W+3 operations. The first W+2 use code 0 (rotate right by one) and the remaining W+1 use code 1 (rotate left by one). op_b is 0. Each op_a equals the result returned for the previous rotate. A new rotate is issued only in the cycle after the previous result was captured, so rotates are issued every RES_LAT+1 cycles.
- R4: The logic group has 24 operations, issued back to back. The codes go OR=2, AND=3, XOR=4, XNOR=5, NOT=6, compare=7. Each code is issued with four operand pairs in this order: (0,0), (0,1), (1,0), (1,1), where 0 means an all-zero word and 1 means an all-one word.
- R5: The arithmetic group has 16 operations, issued back to back. First come ADD=8 over the four operand pairs of R4, then SUB=9 over the same pairs. Then come eight carry cases, in this order:
  - ADD ones+1
  - ADD 0x7FFFFFFF+1
  - ADD msb+msb
  - ADD 0x55555555+0x55555555
  - SUB 0-1
  - SUB msb-1
  - SUB 1-ones
  - ADD ones+ones
- R6: The multiply group has 256 operations with code 10, issued back to back. For step m, op_a = (m div 16) << FIELD_LSB and op_b = (m mod 16) << FIELD_LSB.
- R7: The block captures res_data exactly RES_LAT cycles after each issue. Each capture updates the signature once, as next = (sig << 1) ^ (sig[W-1] ? POLY : 0) ^ res_data, with POLY = 0x00400007. This corresponds to x^32+x^22+x^2+x+1. The signature never changes in a cycle without a capture or a clear.
- R8: done rises one cycle after the final capture. It then holds, with op_valid 0 and the signature stable, until the next accepted start.
- R9: pass is 1 only while done is 1 and the final signature equals GOLDEN.
- R10: A start pulse while a test is running is ignored: the program continues unchanged.
- R11: A start accepted while done reruns the whole program and reproduces the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted while idle or done |
| op_valid | output | 1 | An operation is issued this cycle |
| op_code | output | 4 | Operation code of the issued operation |
| op_a | output | WORD_W | First operand |
| op_b | output | WORD_W | Second operand |
| res_data | input | WORD_W | Result from the datapath, RES_LAT cycles after issue |
| done | output | 1 | Program complete |
| pass | output | 1 | Done and signature equals GOLDEN |
| signature | output | WORD_W | Current compacted signature |

## Verification
On every cycle, the assertions check the following:
- nothing is issued while idle or done;
- a rotate is never issued with a result still in flight;
- the signature only moves on a capture or a clear;
- done holds with a frozen signature;
- pass never appears without done;
- a start while running does not stop the run.

Only the bench scenarios can show the exact operand and code sequence of each group, the chained rotate operands, the signature value, and the agreement of the signature with an independently computed golden value. The same holds for the timing of done, and for the repeatability of the signature after a restart.

// File: rtl/alu_bist_pkg.sv
package alu_bist_pkg;

    typedef enum logic [3:0] {
        OP_ROR  = 4'd0,
        OP_ROL  = 4'd1,
        OP_OR   = 4'd2,
        OP_AND  = 4'd3,
        OP_XOR  = 4'd4,
        OP_XNOR = 4'd5,
        OP_NOT  = 4'd6,
        OP_CMP  = 4'd7,
        OP_ADD  = 4'd8,
        OP_SUB  = 4'd9,
        OP_MUL  = 4'd10
    } op_code_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_LOGIC,
        PH_ARITH,
        PH_MUL,
        PH_DRAIN,
        PH_DONE
    } phase_e;

    localparam int NIB_W   = 4;
    localparam int LOGIC_N = 24;
    localparam int ARITH_N = 16;
    localparam int MUL_N   = 256;

    // rotate chain length for a given word width
    function automatic int rot_steps(input int w);
        return 2 * w + 3;
    endfunction

    // number of leading rotate-right steps
    function automatic int ror_steps(input int w);
        return w + 2;
    endfunction

    function automatic int idx_width(input int w);
        int m;
        m = (rot_steps(w) > MUL_N) ? rot_steps(w) : MUL_N;
        return $clog2(m);
    endfunction

endpackage

// File: rtl/alu_bist_ctrl.sv
module alu_bist_ctrl
    import alu_bist_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cap,
    input  logic             inflight,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             issue,
    output logic             running
);

    localparam int SHIFT_N = rot_steps(WORD_W);
    localparam logic [IDX_W-1:0] SHIFT_LAST = IDX_W'(SHIFT_N - 1);
    localparam logic [IDX_W-1:0] LOGIC_LAST = IDX_W'(LOGIC_N - 1);
    localparam logic [IDX_W-1:0] ARITH_LAST = IDX_W'(ARITH_N - 1);
    localparam logic [IDX_W-1:0] MUL_LAST   = IDX_W'(MUL_N - 1);

    phase_e           ph_q;
    logic [IDX_W-1:0] idx_q;
    logic             wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            idx_q  <= '0;
            wait_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE, PH_DONE: begin
                    if (start) begin
                        ph_q   <= PH_SHIFT;
                        idx_q  <= '0;
                        wait_q <= 1'b0;
                    end
                end
                PH_SHIFT: begin
                    if (!wait_q) begin
                        wait_q <= 1'b1;
                    end else if (cap) begin
                        wait_q <= 1'b0;
                        if (idx_q == SHIFT_LAST) begin
                            ph_q  <= PH_LOGIC;
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                PH_LOGIC: begin
                    if (idx_q == LOGIC_LAST) begin
                        ph_q  <= PH_ARITH;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_ARITH: begin
                    if (idx_q == ARITH_LAST) begin
                        ph_q  <= PH_MUL;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_MUL: begin
                    if (idx_q == MUL_LAST) begin
                        ph_q  <= PH_DRAIN;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_DRAIN: begin
                    if (!inflight) ph_q <= PH_DONE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        phase   = ph_q;
        idx     = idx_q;
        issue   = ((ph_q == PH_SHIFT) && !wait_q) || (ph_q == PH_LOGIC) ||
                  (ph_q == PH_ARITH) || (ph_q == PH_MUL);
        running = (ph_q != PH_IDLE) && (ph_q != PH_DONE);
    end

endmodule

// File: rtl/alu_bist_patgen.sv
module alu_bist_patgen
    import alu_bist_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 8,
    parameter int FIELD_LSB = 0
) (
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] chain,
    output op_code_e          code,
    output logic [WORD_W-1:0] opnd_a,
    output logic [WORD_W-1:0] opnd_b
);

    localparam logic [WORD_W-1:0] W_ZERO = '0;
    localparam logic [WORD_W-1:0] W_ONES = '1;
    localparam logic [WORD_W-1:0] W_ONE  = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_MSB  = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] W_MAXP = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] W_ALT  = {(WORD_W/2){2'b01}};
    localparam logic [IDX_W-1:0]  ROR_N  = IDX_W'(ror_steps(WORD_W));

    function automatic logic [WORD_W-1:0] corner(input logic sel);
        return sel ? W_ONES : W_ZERO;
    endfunction

    always_comb begin
        code   = OP_ROR;
        opnd_a = W_ZERO;
        opnd_b = W_ZERO;
        case (phase)
            PH_SHIFT: begin
                code   = (idx < ROR_N) ? OP_ROR : OP_ROL;
                opnd_a = chain;
            end
            PH_LOGIC: begin
                code   = op_code_e'(4'(OP_OR) + {1'b0, idx[4:2]});
                opnd_a = corner(idx[1]);
                opnd_b = corner(idx[0]);
            end
            PH_ARITH: begin
                if (!idx[3]) begin
                    code   = idx[2] ? OP_SUB : OP_ADD;
                    opnd_a = corner(idx[1]);
                    opnd_b = corner(idx[0]);
                end else begin
                    case (idx[2:0])
                        3'd0: begin code = OP_ADD; opnd_a = W_ONES; opnd_b = W_ONE;  end
                        3'd1: begin code = OP_ADD; opnd_a = W_MAXP; opnd_b = W_ONE;  end
                        3'd2: begin code = OP_ADD; opnd_a = W_MSB;  opnd_b = W_MSB;  end
                        3'd3: begin code = OP_ADD; opnd_a = W_ALT;  opnd_b = W_ALT;  end
                        3'd4: begin code = OP_SUB; opnd_a = W_ZERO; opnd_b = W_ONE;  end
                        3'd5: begin code = OP_SUB; opnd_a = W_MSB;  opnd_b = W_ONE;  end
                        3'd6: begin code = OP_SUB; opnd_a = W_ONE;  opnd_b = W_ONES; end
                        default: begin code = OP_ADD; opnd_a = W_ONES; opnd_b = W_ONES; end
                    endcase
                end
            end
            PH_MUL: begin
                code   = OP_MUL;
                opnd_a = WORD_W'(idx[2*NIB_W-1:NIB_W]) << FIELD_LSB;
                opnd_b = WORD_W'(idx[NIB_W-1:0]) << FIELD_LSB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_bist_misr.sv
module alu_bist_misr #(
    parameter int                WORD_W = 32,
    parameter logic [WORD_W-1:0] POLY   = WORD_W'(32'h0040_0007)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] sig
);

    logic [WORD_W-1:0] sig_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sig_q <= '0;
        end else if (en) begin
            sig_q <= {sig_q[WORD_W-2:0], 1'b0} ^ (sig_q[WORD_W-1] ? POLY : '0) ^ data;
        end
    end

    assign sig = sig_q;

endmodule

// File: rtl/alu_bist_seq.sv
module alu_bist_seq
    import alu_bist_pkg::*;
#(
    parameter int                WORD_W    = 32,
    parameter int                RES_LAT   = 2,
    parameter int                FIELD_LSB = 0,
    parameter logic [WORD_W-1:0] MISR_POLY = WORD_W'(32'h0040_0007),
    parameter logic [WORD_W-1:0] GOLDEN    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              op_valid,
    output logic [3:0]        op_code,
    output logic [WORD_W-1:0] op_a,
    output logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] res_data,
    output logic              done,
    output logic              pass,
    output logic [WORD_W-1:0] signature
);

    localparam int IDX_W = idx_width(WORD_W);

    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    logic              issue;
    logic              running;
    logic [RES_LAT-1:0] vpipe;
    logic              cap;
    logic              inflight;
    logic              launch;
    logic [WORD_W-1:0] chain_q;
    op_code_e          code;

    assign launch   = start && !running;
    assign cap      = vpipe[RES_LAT-1];
    assign inflight = |vpipe;

    alu_bist_ctrl #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cap      (cap),
        .inflight (inflight),
        .phase    (phase),
        .idx      (idx),
        .issue    (issue),
        .running  (running)
    );

    alu_bist_patgen #(
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W),
        .FIELD_LSB (FIELD_LSB)
    ) u_patgen (
        .phase  (phase),
        .idx    (idx),
        .chain  (chain_q),
        .code   (code),
        .opnd_a (op_a),
        .opnd_b (op_b)
    );

    // issue-to-capture delay line, sized by the result latency
    generate
        if (RES_LAT == 1) begin : g_lat_one
            always_ff @(posedge clk) begin
                if (rst) vpipe <= '0;
                else     vpipe <= issue;
            end
        end else begin : g_lat_many
            always_ff @(posedge clk) begin
                if (rst) vpipe <= '0;
                else     vpipe <= {vpipe[RES_LAT-2:0], issue};
            end
        end
    endgenerate

    // rotate chain operand: seeded with one, then fed by returned results
    always_ff @(posedge clk) begin
        if (rst || launch) begin
            chain_q <= WORD_W'(1);
        end else if (cap && (phase == PH_SHIFT)) begin
            chain_q <= res_data;
        end
    end

    alu_bist_misr #(
        .WORD_W (WORD_W),
        .POLY   (MISR_POLY)
    ) u_misr (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .en    (cap),
        .data  (res_data),
        .sig   (signature)
    );

    assign op_valid = issue;
    assign op_code  = 4'(code);
    assign done     = (phase == PH_DONE);
    assign pass     = done && (signature == GOLDEN);

endmodule

// File: rtl/alu_bist_seq_chk.sv
module alu_bist_seq_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] signature,
    input logic              done,
    input logic              pass,
    input logic              cap,
    input logic              inflight,
    input logic              running
);

    // R1
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !running |-> !op_valid);

    // R2
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !running) |=> (signature == '0 && op_valid &&
                                 op_code == 4'd0 && op_a == WORD_W'(1)));

    // R3
    a_r3_serial_rotate: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code <= 4'd1) |-> !inflight);

    // R4
    a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_code <= 4'd10));

    // R7
    a_r7_sig_hold: assert property (@(posedge clk) disable iff (rst)
        (!cap && !(start && !running)) |=> $stable(signature));

    // R8
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!op_valid && !inflight));

    // R8
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(signature)));

    // R9
    a_r9_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    // R10
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && running && op_valid) |=> running);

endmodule

bind alu_bist_seq alu_bist_seq_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_a      (op_a),
    .signature (signature),
    .done      (done),
    .pass      (pass),
    .cap       (cap),
    .inflight  (inflight),
    .running   (running)
);

// File: tb/test_alu_bist_seq.sv
module test_alu_bist_seq;

    localparam int W       = 32;
    localparam int LAT     = 2;
    localparam int FLD     = 0;
    localparam int SHIFT_N = 2 * W + 3;
    localparam int TOTAL   = SHIFT_N + 24 + 16 + 256;
    localparam logic [W-1:0] POLY = 32'h0040_0007;

    // behavioural op program: returns {code, a, b}
    function automatic logic [2*W+3:0] gen_op(input int k, input logic [W-1:0] chain);
        logic [3:0]   c;
        logic [W-1:0] a, b, ones, msb;
        int j;
        ones = '1;
        msb  = {1'b1, {(W-1){1'b0}}};
        c = 4'd0; a = '0; b = '0;
        if (k < SHIFT_N) begin
            c = (k < W + 2) ? 4'd0 : 4'd1;
            a = chain;
        end else if (k < SHIFT_N + 24) begin
            j = k - SHIFT_N;
            c = 4'(2 + j / 4);
            a = ((j % 4) >= 2) ? ones : '0;
            b = ((j % 2) == 1) ? ones : '0;
        end else if (k < SHIFT_N + 40) begin
            j = k - SHIFT_N - 24;
            if (j < 8) begin
                c = (j < 4) ? 4'd8 : 4'd9;
                a = ((j % 4) >= 2) ? ones : '0;
                b = ((j % 2) == 1) ? ones : '0;
            end else begin
                case (j - 8)
                    0: begin c = 4'd8; a = ones;       b = 1;    end
                    1: begin c = 4'd8; a = ones >> 1;  b = 1;    end
                    2: begin c = 4'd8; a = msb;        b = msb;  end
                    3: begin c = 4'd8; a = {(W/2){2'b01}}; b = {(W/2){2'b01}}; end
                    4: begin c = 4'd9; a = '0;         b = 1;    end
                    5: begin c = 4'd9; a = msb;        b = 1;    end
                    6: begin c = 4'd9; a = 1;          b = ones; end
                    default: begin c = 4'd8; a = ones; b = ones; end
                endcase
            end
        end else begin
            j = k - SHIFT_N - 40;
            c = 4'd10;
            a = W'(j / 16) << FLD;
            b = W'(j % 16) << FLD;
        end
        return {c, a, b};
    endfunction

    // behavioural datapath under test
    function automatic logic [W-1:0] uut(input logic [3:0] c, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
        case (c)
            4'd0:  return {a[0], a[W-1:1]};
            4'd1:  return {a[W-2:0], a[W-1]};
            4'd2:  return a | b;
            4'd3:  return a & b;
            4'd4:  return a ^ b;
            4'd5:  return ~(a ^ b);
            4'd6:  return ~a;
            4'd7:  return (a == b) ? W'(1) : W'(0);
            4'd8:  return a + b;
            4'd9:  return a - b;
            4'd10: return a * b;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] misr(input logic [W-1:0] s, input logic [W-1:0] d);
        return {s[W-2:0], 1'b0} ^ (s[W-1] ? POLY : '0) ^ d;
    endfunction

    function automatic logic [W-1:0] ref_sig();
        logic [W-1:0] s, ch, r;
        logic [2*W+3:0] o;
        s  = '0;
        ch = 1;
        for (int k = 0; k < TOTAL; k++) begin
            o = gen_op(k, ch);
            r = uut(o[2*W+3:2*W], o[2*W-1:W], o[W-1:0]);
            s = misr(s, r);
            if (k < SHIFT_N) ch = r;
        end
        return s;
    endfunction

    localparam logic [W-1:0] GOLD = ref_sig();

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op_valid;
    logic [3:0]   op_code;
    logic [W-1:0] op_a, op_b, res_data, signature;
    logic         done, pass;
    logic         b_valid, b_done, b_pass;
    logic [3:0]   b_code;
    logic [W-1:0] b_a, b_b, b_sig;

    always #4 clk = ~clk;

    alu_bist_seq #(.WORD_W(W), .RES_LAT(LAT), .FIELD_LSB(FLD), .GOLDEN(GOLD)) i_alu_bist_seq (
        .clk(clk), .rst(rst), .start(start), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .res_data(res_data), .done(done), .pass(pass),
        .signature(signature));

    alu_bist_seq #(.WORD_W(W), .RES_LAT(LAT), .FIELD_LSB(FLD), .GOLDEN(GOLD ^ W'(1))) i_alu_bist_seq_mis (
        .clk(clk), .rst(rst), .start(start), .op_valid(b_valid), .op_code(b_code),
        .op_a(b_a), .op_b(b_b), .res_data(res_data), .done(b_done), .pass(b_pass),
        .signature(b_sig));

    // datapath model with fixed latency
    logic [W-1:0] pd [LAT];
    logic         pv [LAT];
    always @(posedge clk) begin
        for (int i = LAT - 1; i > 0; i--) begin
            pd[i] <= pd[i-1];
            pv[i] <= rst ? 1'b0 : pv[i-1];
        end
        pd[0] <= uut(op_code, op_a, op_b);
        pv[0] <= rst ? 1'b0 : op_valid;
    end
    assign res_data = pd[LAT-1];

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic string tag_of(input int k);
        if (k < SHIFT_N)           return "R3";
        else if (k < SHIFT_N + 24) return "R4";
        else if (k < SHIFT_N + 40) return "R5";
        else                       return "R6";
    endfunction

    // cycle-by-cycle reference model
    bit           mon_on = 0;
    bit           clr_pending = 0;
    bit           run = 0;
    bit           exp_done = 0;
    bit           exp_v;
    int           k = 0;
    int           wait_cnt = 0;
    int           due = 0;
    int           caps = 0;
    logic [W-1:0] msig = '0;
    logic [W-1:0] mchain = 1;
    logic [2*W+3:0] eop;

    always @(negedge clk) begin
        if (mon_on) begin
            if (clr_pending) begin
                clr_pending = 0;
                msig = '0; k = 0; wait_cnt = 0; due = 0; caps = 0;
                exp_done = 0; run = 1; mchain = 1;
                chk(op_valid && op_code == 4'd0 && op_a == W'(1) && signature == '0,
                    "R2", {op_code, op_a[27:0]}, W'(1));
            end
            if (due > 0) begin
                due--;
                if (due == 0) begin exp_done = 1; run = 0; end
            end
            chk(done == exp_done, "R8", W'(done), W'(exp_done));
            chk(signature == msig, "R7", signature, msig);
            if (exp_done) chk(pass == (msig == GOLD), "R9", W'(pass), W'(msig == GOLD));
            if (!run) chk(!op_valid, "R1", W'(op_valid), '0);
            exp_v = run && (wait_cnt == 0) && (k < TOTAL);
            if (run) chk(op_valid == exp_v, tag_of(k), W'(op_valid), W'(exp_v));
            if (exp_v) begin
                eop = gen_op(k, mchain);
                chk(op_code == eop[2*W+3:2*W], tag_of(k), W'(op_code), W'(eop[2*W+3:2*W]));
                chk(op_a == eop[2*W-1:W], tag_of(k), op_a, eop[2*W-1:W]);
                chk(op_b == eop[W-1:0], tag_of(k), op_b, eop[W-1:0]);
                if (k < SHIFT_N) begin
                    mchain   = uut(eop[2*W+3:2*W], eop[2*W-1:W], eop[W-1:0]);
                    wait_cnt = LAT;
                end
                k++;
            end else if (wait_cnt > 0) begin
                wait_cnt--;
            end
            if (pv[LAT-1]) begin
                msig = misr(msig, pd[LAT-1]);
                caps++;
                if (caps == TOTAL) due = 2;
            end
        end
    end

    task automatic launch(input bit accepted);
        @(negedge clk); #1;
        start = 1'b1;
        if (accepted) clr_pending = 1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    logic [W-1:0] sig1;

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!op_valid && !done && !pass && signature == '0, "R1",
            {signature[W-4:0], op_valid, done, pass}, '0);
        mon_on = 1;

        launch(1'b1);
        repeat (205) @(negedge clk);
        #1 start = 1'b1;               // R10: start while running
        @(negedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(op_valid && op_code != 4'd0 && !done, "R10", W'(op_code), W'(2));

        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done && pass, "R9", W'(pass), W'(1));
        chk(b_done && !b_pass, "R9", W'(b_pass), '0);
        chk(signature == GOLD, "R7", signature, GOLD);
        sig1 = signature;
        repeat (5) @(negedge clk);
        chk(done && !op_valid && signature == sig1, "R8", signature, sig1);

        launch(1'b1);                  // R11: rerun from done
        @(negedge clk);
        chk(!done, "R11", W'(done), '0);
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(signature == sig1 && pass, "R11", signature, sig1);
        summary();
    end

endmodule